// File: doc/BRIEF.md
# Single-Frame Transmit Buffer with Retransmit

This block sits between a host that loads outgoing bytes and a transmit framer that sends them. It holds exactly one frame. The host writes bytes one at a time. It can also flush the buffer or start a transmission, and it reads a status byte that is always present on its interface. After a start command, an internal sequencer counts out a fixed lead-in and a header period, which stand in for preamble and delimiter generation. It then takes payload bytes from the buffer at a steady symbol rate and hands them to the transmit side on a valid/byte pair.

The first byte of every frame carries the length of the rest of the frame. When the last byte has gone out, the buffer rewinds to the start of the frame, so a second start command sends the same frame again. If the host writes after a completed transmission, the old frame is thrown away before the new byte is stored. If the sequencer needs a byte that the host has not yet written, it raises a sticky underflow flag and drops the frame. Only a flush clears that flag.

Top module: `txbuf_retx`

## Requirements
- R1: After a synchronous active-low reset the status byte is zero, `busy` is low, and `tx_valid`, `sfd_sent` and `frame_done` are low.
- R2: Each `wr_en` cycle appends `wr_data` to the buffer, which holds up to DEPTH bytes. A write to a full buffer is dropped and sets the overflow bit (status bit 1). The overflow bit stays set until a flush.
- R3: `start` is accepted only when the block is idle, the underflow bit is clear and `flush` is low. A `start` at any other time has no effect, and `busy` stays high from the accepting edge until the frame ends.
- R4: After an accepted `start`, 12 symbol periods of lead-in follow, then HDR_SYMS symbol periods of header. `sfd_sent` pulses for one cycle in the cycle after the header ends. One symbol period is SYM_CYC clocks.
- R5: Bytes leave the buffer only after the header. The first byte is fetched on the edge after the header ends, and each later byte follows BYTE_SYMS symbol periods after the one before it. Each fetched byte appears on `tx_byte` with a one-cycle `tx_valid` on the next cycle. Bits 6:0 of the first byte give N, and the frame is N+1 bytes long.
- R6: If a byte is due and the buffer holds no unread byte, the underflow bit (status bit 0) is set and the transmission ends at once. No further byte is sent and `frame_done` does not pulse.
- R7: The underflow bit stays set through writes, starts and transmissions, and only a flush clears it.
- R8: When the last byte of a frame is sent, `frame_done` pulses in the same cycle as its `tx_valid`. The sent bit (status bit 3) then sets, and the read position returns to the frame start, so a later accepted `start` resends identical bytes.
- R9: A write while the sent bit is set, with underflow clear, first discards the stored frame. The new byte becomes the first byte of a fresh frame. Any write or accepted `start` clears the sent bit.
- R10: `flush` empties the buffer, clears the underflow, overflow and sent bits, and ends any transmission in progress without a `frame_done`.
- R11: The status byte is {4'b0, sent, busy, overflow, underflow}. It reflects the state after each clock edge and is present on every host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte to store |
| flush | input | 1 | Empty buffer and clear all sticky status |
| start | input | 1 | Start-transmit strobe |
| stat | output | 8 | Status byte {0000, sent, busy, overflow, underflow} |
| tx_valid | output | 1 | One-cycle pulse: `tx_byte` carries a payload byte |
| tx_byte | output | 8 | Byte handed to the transmit side |
| sfd_sent | output | 1 | One-cycle pulse at the end of the header period |
| frame_done | output | 1 | One-cycle pulse with the last byte of a frame |
| busy | output | 1 | A transmission is in progress |

## Verification
The bench builds the block with DEPTH=16, SYM_CYC=2, HDR_SYMS=10 and BYTE_SYMS=2. With these values the lead-in takes 24 cycles, the header 20 cycles and each byte slot 4 cycles. A 16-byte frame fills the buffer exactly, so one extra write reaches the overflow path. The short periods also put streaming writes during the lead-in, a flush in the middle of the payload and a start while busy within a few hundred cycles, and a behavioural reference model follows every one of them cycle by cycle.

// File: rtl/txbuf_pkg.sv
// Shared types and constants for the single-frame transmit buffer.
// Assumes: status bit positions are fixed by R11 and used by host software.
package txbuf_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_HDR  = 2'd2,
        SQ_PAY  = 2'd3
    } seq_state_t;

    localparam int ST_UF   = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_BUSY = 2;
    localparam int ST_SENT = 3;

    localparam int LEAD_SYMS = 12;
endpackage

// File: rtl/txbuf_store.sv
// Byte storage for one frame with write and read pointers.
// A fresh write discards the old frame and stores the byte at position 0.
// A rewind sends the read pointer back to the frame start.
// Assumes: clr has priority over every other request; rd_adv is raised only when not empty.
module txbuf_store #(
    parameter int DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_en,
    input  logic       wr_fresh,
    input  logic [7:0] wr_data,
    input  logic       rd_adv,
    input  logic       rd_rewind,
    output logic [7:0] rd_byte,
    output logic       empty,
    output logic       full,
    output logic       ovf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_AT = PW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    assign full    = (wr_ptr == FULL_AT);
    assign empty   = (rd_ptr == wr_ptr);
    assign rd_byte = mem[rd_ptr[AW-1:0]];
    assign ovf_evt = wr_en && !clr && !wr_fresh && full;

    // Store the host byte at the write position, or at 0 on a fresh frame.
    always_ff @(posedge clk) begin
        if (!clr && wr_en) begin
            if (wr_fresh)
                mem[0] <= wr_data;
            else if (!full)
                mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    // Move the pointers: clear, restart, append, advance or rewind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (wr_en && wr_fresh) begin
            wr_ptr <= PW'(1);
            rd_ptr <= '0;
        end else begin
            if (wr_en && !full)
                wr_ptr <= wr_ptr + PW'(1);
            if (rd_rewind)
                rd_ptr <= '0;
            else if (rd_adv)
                rd_ptr <= rd_ptr + PW'(1);
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (wr_ptr == $past(wr_ptr))); // R2
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> !empty); // R6
    AST_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fresh && !clr) |=> (wr_ptr == PW'(1) && rd_ptr == '0)); // R9
    AST_REWIND_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rewind && !clr && !(wr_en && wr_fresh)) |=> (rd_ptr == '0)); // R8
    AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= wr_ptr); // R5
endmodule

// File: rtl/txbuf_seq.sv
// Transmit sequencer: a lead-in, then a header, then paced byte fetches.
// It stands in for the framer and consumes one byte per slot.
// Assumes: go is already qualified by the top (idle, no underflow, no flush).
// abort ends any frame at once.
module txbuf_seq #(
    parameter int SYM_CYC   = 16,
    parameter int HDR_SYMS  = 10,
    parameter int BYTE_SYMS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       abort,
    input  logic       empty,
    input  logic [7:0] rd_byte,
    output logic       rd_adv,
    output logic       rd_rewind,
    output logic       uf_evt,
    output logic       done_evt,
    output logic       busy,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       sfd_sent,
    output logic       frame_done
);
    import txbuf_pkg::*;

    localparam int LEAD_CYC = LEAD_SYMS * SYM_CYC;
    localparam int HDR_CYC  = HDR_SYMS * SYM_CYC;
    localparam int BYTE_CYC = BYTE_SYMS * SYM_CYC;
    localparam int MAX_A    = (LEAD_CYC > HDR_CYC) ? LEAD_CYC : HDR_CYC;
    localparam int MAX_CYC  = (MAX_A > BYTE_CYC) ? MAX_A : BYTE_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);

    seq_state_t    state;
    logic [TW-1:0] timer;
    logic [6:0]    idx;
    logic [6:0]    len_q;
    logic [6:0]    len_now;
    logic          fetch;
    logic          last;

    assign fetch     = (state == SQ_PAY) && (timer == '0) && !abort;
    assign len_now   = (idx == 7'd0) ? rd_byte[6:0] : len_q;
    assign last      = (idx == len_now);
    assign uf_evt    = fetch && empty;
    assign rd_adv    = fetch && !empty && !last;
    assign rd_rewind = fetch && !empty && last;
    assign done_evt  = rd_rewind;
    assign busy      = (state != SQ_IDLE);

    // Walk lead-in, header and payload slots and count bytes against the length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            timer <= '0;
            idx   <= '0;
            len_q <= '0;
        end else if (abort) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE: if (go) begin
                    state <= SQ_LEAD;
                    timer <= TW'(LEAD_CYC - 1);
                end
                SQ_LEAD: if (timer == '0) begin
                    state <= SQ_HDR;
                    timer <= TW'(HDR_CYC - 1);
                end else begin
                    timer <= timer - TW'(1);
                end
                SQ_HDR: if (timer == '0) begin
                    state <= SQ_PAY;
                    timer <= '0;
                    idx   <= '0;
                end else begin
                    timer <= timer - TW'(1);
                end
                SQ_PAY: if (timer != '0) begin
                    timer <= timer - TW'(1);
                end else if (empty) begin
                    state <= SQ_IDLE;
                end else begin
                    if (idx == 7'd0)
                        len_q <= rd_byte[6:0];
                    if (last) begin
                        state <= SQ_IDLE;
                    end else begin
                        idx   <= idx + 7'd1;
                        timer <= TW'(BYTE_CYC - 1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Register the transmit-side pulses and the byte handed out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid   <= 1'b0;
            tx_byte    <= '0;
            sfd_sent   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            tx_valid   <= fetch && !empty;
            sfd_sent   <= (state == SQ_HDR) && (timer == '0) && !abort;
            frame_done <= done_evt;
            if (fetch && !empty)
                tx_byte <= rd_byte;
        end
    end

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_LEAD || state == SQ_HDR) && !abort) |=> busy); // R3
    AST_GO_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && !abort) |=> (state == SQ_LEAD)); // R4
    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(state) == SQ_PAY)); // R5
    AST_UF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (!busy && !tx_valid && !frame_done)); // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (!busy && frame_done && tx_valid)); // R8
endmodule

// File: rtl/txbuf_flags.sv
// Sticky status flags: underflow, overflow and frame-sent.
// Assumes: flush clears all three and takes priority.
// A completion outranks a clear in the same cycle.
module txbuf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic uf_evt,
    input  logic ovf_evt,
    input  logic done_evt,
    input  logic clr_sent,
    output logic uf,
    output logic ovf,
    output logic sent
);
    // Set, hold and clear the three sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            uf   <= 1'b0;
            ovf  <= 1'b0;
            sent <= 1'b0;
        end else begin
            if (uf_evt)
                uf <= 1'b1;
            if (ovf_evt)
                ovf <= 1'b1;
            if (done_evt)
                sent <= 1'b1;
            else if (clr_sent)
                sent <= 1'b0;
        end
    end

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !flush) |=> uf); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf); // R2
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!uf && !ovf && !sent)); // R10
endmodule

// File: rtl/txbuf_retx.sv
// Single-frame transmit buffer with retransmit, top level.
// Qualifies the host strobes and builds the status byte.
// Wires together the storage, the sequencer and the sticky flags.
// Assumes: all host inputs are synchronous to clk.
// DEPTH is at most 128, because the length field is 7 bits.
module txbuf_retx #(
    parameter int DEPTH     = 128,
    parameter int SYM_CYC   = 16,
    parameter int HDR_SYMS  = 10,
    parameter int BYTE_SYMS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       flush,
    input  logic       start,
    output logic [7:0] stat,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       sfd_sent,
    output logic       frame_done,
    output logic       busy
);
    import txbuf_pkg::*;

    logic       go;
    logic       fresh;
    logic       uf, ovf, sent;
    logic       uf_evt, ovf_evt, done_evt;
    logic       rd_adv, rd_rewind;
    logic       empty, full;
    logic [7:0] rd_byte;

    assign go    = start && !busy && !uf && !flush;
    assign fresh = wr_en && sent && !uf;

    // Assemble the status byte from the flags and the busy state.
    always_comb begin
        stat          = '0;
        stat[ST_UF]   = uf;
        stat[ST_OVF]  = ovf;
        stat[ST_BUSY] = busy;
        stat[ST_SENT] = sent;
    end

    txbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .wr_en     (wr_en),
        .wr_fresh  (fresh),
        .wr_data   (wr_data),
        .rd_adv    (rd_adv),
        .rd_rewind (rd_rewind),
        .rd_byte   (rd_byte),
        .empty     (empty),
        .full      (full),
        .ovf_evt   (ovf_evt)
    );

    txbuf_seq #(
        .SYM_CYC   (SYM_CYC),
        .HDR_SYMS  (HDR_SYMS),
        .BYTE_SYMS (BYTE_SYMS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .abort      (flush),
        .empty      (empty),
        .rd_byte    (rd_byte),
        .rd_adv     (rd_adv),
        .rd_rewind  (rd_rewind),
        .uf_evt     (uf_evt),
        .done_evt   (done_evt),
        .busy       (busy),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .sfd_sent   (sfd_sent),
        .frame_done (frame_done)
    );

    txbuf_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .uf_evt   (uf_evt),
        .ovf_evt  (ovf_evt),
        .done_evt (done_evt),
        .clr_sent (wr_en || go),
        .uf       (uf),
        .ovf      (ovf),
        .sent     (sent)
    );

    AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && uf && !busy) |=> !busy); // R3
    AST_FULL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !sent && !flush) |=> stat[ST_OVF]); // R2
endmodule

// File: tb/tb_txbuf_retx.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module tb_txbuf_retx;
    localparam int DEPTH = 16;
    localparam int SYMC  = 2;
    localparam int HDRS  = 10;
    localparam int BYTS  = 2;
    localparam int LEADC = 12 * SYMC;
    localparam int HDRC  = HDRS * SYMC;
    localparam int BYTEC = BYTS * SYMC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flush = 1'b0;
    logic       start = 1'b0;
    logic [7:0] stat;
    logic       tx_valid, sfd_sent, frame_done, busy;
    logic [7:0] tx_byte;

    txbuf_retx #(.DEPTH(DEPTH), .SYM_CYC(SYMC), .HDR_SYMS(HDRS), .BYTE_SYMS(BYTS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
        .start(start), .stat(stat), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .sfd_sent(sfd_sent), .frame_done(frame_done), .busy(busy)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;
    int cyc = 0;
    int sfd_cyc = -1;
    int first_cyc = -1;
    byte unsigned got[$];

    // Reference model state.
    int m_state, m_tm, m_idx, m_len, m_rd, m_wr;
    int m_mem [DEPTH];
    bit m_uf, m_ovf, m_sent;
    bit e_vld, e_sfd, e_done;
    int e_byte;

    task automatic chk(int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model: one step per rising edge from the applied inputs.
    always @(posedge clk) begin
        bit go, af, ufe, dn;
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_tm = 0; m_idx = 0; m_len = 0; m_rd = 0; m_wr = 0;
            m_uf = 0; m_ovf = 0; m_sent = 0; e_vld = 0; e_sfd = 0; e_done = 0; e_byte = 0;
        end else begin
            e_vld = 0; e_sfd = 0; e_done = 0; ufe = 0; dn = 0;
            go = start && (m_state == 0) && !m_uf && !flush;
            af = wr_en && m_sent && !m_uf;
            if (flush) m_state = 0;
            else case (m_state)
                0: if (go) begin m_state = 1; m_tm = LEADC - 1; end
                1: if (m_tm == 0) begin m_state = 2; m_tm = HDRC - 1; end else m_tm--;
                2: if (m_tm == 0) begin m_state = 3; m_tm = 0; m_idx = 0; e_sfd = 1; end else m_tm--;
                default: if (m_tm != 0) m_tm--;
                    else if (m_rd == m_wr) begin ufe = 1; m_state = 0; end
                    else begin
                        e_vld = 1; e_byte = m_mem[m_rd];
                        if (m_idx == 0) m_len = e_byte % 128;
                        if (m_idx == m_len) begin dn = 1; e_done = 1; m_state = 0; m_rd = 0; end
                        else begin m_rd++; m_idx++; m_tm = BYTEC - 1; end
                    end
            endcase
            if (flush) begin
                m_uf = 0; m_ovf = 0; m_sent = 0; m_wr = 0; m_rd = 0;
            end else begin
                if (ufe) m_uf = 1;
                if (dn) m_sent = 1; else if (wr_en || go) m_sent = 0;
                if (wr_en) begin
                    if (af) begin m_mem[0] = wr_data; m_wr = 1; m_rd = 0; end
                    else if (m_wr == DEPTH) m_ovf = 1;
                    else begin m_mem[m_wr] = wr_data; m_wr++; end
                end
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(tx_valid, e_vld, "R5 tx_valid");
            if (e_vld) chk(tx_byte, e_byte, "R5 tx_byte");
            chk(sfd_sent, e_sfd, "R4 sfd_sent");
            chk(frame_done, e_done, "R8 frame_done");
            chk(busy, m_state != 0, "R3 busy");
            chk(stat, {m_sent, m_state != 0, m_ovf, m_uf}, "R11 status");
            if (tx_valid) begin
                got.push_back(tx_byte);
                if (first_cyc < 0) first_cyc = cyc;
            end
            if (sfd_sent) sfd_cyc = cyc;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask
    task automatic wr(int b);
        wr_en = 1; wr_data = 8'(b); tick(); wr_en = 0;
    endtask
    task automatic go_tx();
        start = 1; tick(); start = 0;
    endtask
    task automatic do_flush();
        flush = 1; tick(); flush = 0;
    endtask
    task automatic wait_idle();
        tick(2);
        while (busy) tick();
        tick();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        byte unsigned first[$];
        int t0;
        tick(3);
        rst_n = 1;
        tick();
        chk(stat, 0, "R1 status after reset");
        chk(busy, 0, "R1 busy after reset");

        // Basic frame: length 3, with a start while busy that must be ignored.
        wr(3); wr(8'h11); wr(8'h22); wr(8'h33);
        got.delete(); sfd_cyc = -1; first_cyc = -1;
        t0 = cyc;
        go_tx();
        tick(5);
        go_tx(); // R3 ignored while busy
        wait_idle();
        chk(sfd_cyc - t0, LEADC + HDRC + 1, "R4 sfd timing");
        chk(first_cyc - t0, LEADC + HDRC + 2, "R5 first byte timing");
        chk(got.size(), 4, "R5 frame length");
        if (got.size() == 4) chk(got[3], 8'h33, "R5 last byte");
        first = got;
        chk(stat[3], 1, "R8 sent bit");

        // Retransmit the same frame.
        got.delete();
        go_tx();
        wait_idle();
        chk(got.size(), first.size(), "R8 retransmit size");
        foreach (first[i]) if (i < got.size()) chk(got[i], first[i], "R8 retransmit byte");

        // Write after done auto-flushes.
        wr(2); wr(8'h44); wr(8'h55);
        got.delete();
        go_tx();
        wait_idle();
        chk(got.size(), 3, "R9 fresh frame size");
        if (got.size() == 3) begin
            chk(got[0], 2, "R9 fresh byte0");
            chk(got[2], 8'h55, "R9 fresh byte2");
        end

        // Underflow: length 5 with only two data bytes.
        do_flush();
        wr(5); wr(8'h66); wr(8'h77);
        got.delete();
        go_tx();
        wait_idle();
        chk(stat[0], 1, "R6 underflow set");
        chk(got.size(), 3, "R6 bytes before stop");
        wr(8'h88);
        go_tx();
        tick(2);
        chk(busy, 0, "R3 start ignored on underflow");
        chk(stat[0], 1, "R7 underflow sticky");
        do_flush();
        chk(stat, 0, "R10 flush clears status");

        // Overflow: 17 writes into 16 entries.
        wr(15);
        for (int i = 1; i < 17; i++) wr(8'h80 + i);
        chk(stat[1], 1, "R2 overflow set");
        got.delete();
        go_tx();
        wait_idle();
        chk(got.size(), 16, "R2 dropped byte not sent");
        if (got.size() == 16) chk(got[15], 8'h8F, "R2 last stored byte");
        chk(stat[1], 1, "R2 overflow sticky");
        do_flush();

        // Streaming writes during the lead-in.
        wr(2);
        got.delete();
        go_tx();
        tick(3);
        wr(8'hA1); wr(8'hA2);
        wait_idle();
        chk(got.size(), 3, "R5 streamed frame");
        chk(stat[3], 1, "R8 streamed frame sent");

        // Flush in mid-payload, then start on an empty buffer.
        go_tx();
        tick(LEADC + HDRC + 3);
        do_flush();
        chk(busy, 0, "R10 flush aborts");
        chk(stat, 0, "R10 flush status");
        go_tx();
        wait_idle();
        chk(stat[0], 1, "R6 underflow on empty");
        do_flush();
        tick(3);
        finish_run();
    end
endmodule